// File: doc/BRIEF.md
# Two-Level DMA Channel Arbiter

The block chooses which DMA channel the transfer engine serves next. Each channel has three inputs: a request line, an enable bit and a two-bit software priority. A channel takes part in arbitration only when its request is high and it is enabled.

The choice is made in two stages. The first stage keeps the requesters that share the highest software level. The second stage picks the lowest channel number among them. The winner is registered as a one-hot grant and a binary index. The grant then stays unchanged until the engine reports that the beat is complete. After that, one idle cycle passes before the next decision.

The engine watches `grantValid`. It performs one beat for the channel in `grantIdx` and pulses `beatDone` in the cycle it finishes.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, `grantValid` is 0, `grantOneHot` is all zeros and `grantIdx` is 0.
- R2: A channel is eligible when its request and enable bits are both 1. Its level is `chanPrio[2c+1:2c]`, where 3 is the highest, 2 is high, 1 is medium and 0 is the lowest. An eligible channel on a higher level always beats every eligible channel on a lower level.
- R3: Among eligible channels on the same, highest level, the lowest channel number wins.
- R4: A channel whose enable bit is 0 is never granted, whatever its request and priority.
- R5: When no channel is eligible and no grant is held, `grantValid` is 0, `grantOneHot` is 0 and `grantIdx` is 0.
- R6: While a grant is held and `beatDone` is 0, the grant outputs stay unchanged, even if requests, enables or priorities change.
- R7: A decision is taken in an idle cycle and appears on the outputs one clock later. A `beatDone` seen while a grant is held clears the grant at the next edge. The following cycle is idle, and a new decision appears one clock after that.
- R8: `grantOneHot` has at most one bit set, and when `grantValid` is 1 that bit is at position `grantIdx`.
- R9: `beatDone` has no effect while no grant is held. A pending eligible request is still granted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chanReq | input | NUM_CH | Request line per channel |
| chanEn | input | NUM_CH | Enable bit per channel |
| chanPrio | input | 2*NUM_CH | Software level per channel, two bits each |
| beatDone | input | 1 | Engine reports that the granted beat is complete |
| grantOneHot | output | NUM_CH | One-hot grant |
| grantIdx | output | $clog2(NUM_CH) | Index of the granted channel |
| grantValid | output | 1 | A grant is held |

## Verification
The bench sets requesters on different levels against each other. A design that reversed the level encoding, or compared channel numbers before levels, would grant the wrong channel. It also fills one level with several channels, where a tie-break favouring the highest index would show up as the wrong `grantIdx`.

A disabled channel is made the strongest requester, and a missing enable mask would grant it. While a grant is held, a higher-priority request is raised; a design that re-arbitrates mid-beat would switch channels. Finally, `beatDone` is pulsed while the arbiter is idle; a design that let this pulse block or swallow the pending grant would leave `grantValid` low.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int PRIO_W = 2;
  localparam int NUM_LEVELS = 1 << PRIO_W;

  typedef enum logic {ARB_IDLE = 1'b0, ARB_HOLD = 1'b1} arbState_e;

  typedef struct packed {
    logic loadGrant;
    logic clearGrant;
  } arbStrobe_t;
endpackage

// File: rtl/dma_arb_control.sv
module dma_arb_control
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyElig,
  input  logic       beatDone,
  output arbStrobe_t strb
);
  arbState_e state, stateNext;

  always_comb begin
    strb = '0;
    stateNext = state;
    case (state)
      ARB_IDLE: if (anyElig) begin
        strb.loadGrant = 1'b1;
        stateNext = ARB_HOLD;
      end
      ARB_HOLD: if (beatDone) begin
        strb.clearGrant = 1'b1;
        stateNext = ARB_IDLE;
      end
      default: stateNext = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ARB_IDLE;
    else       state <= stateNext;
  end

  // R9: idle with an eligible requester always moves to hold
  a_r9_idle_grants: assert property (@(posedge clk) disable iff (!rstN)
    (state == ARB_IDLE && anyElig) |=> (state == ARB_HOLD));

  // R7: hold leaves only on beat completion
  a_r7_hold_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (state == ARB_HOLD && !beatDone) |=> (state == ARB_HOLD));
endmodule

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        chanReq,
  input  logic [NUM_CH-1:0]        chanEn,
  input  logic [PRIO_W*NUM_CH-1:0] chanPrio,
  input  logic                     beatDone,
  input  arbStrobe_t               strb,
  output logic                     anyElig,
  output logic [NUM_CH-1:0]        grantOneHot,
  output logic [IDX_W-1:0]         grantIdx,
  output logic                     grantValid
);
  logic [NUM_CH-1:0] eligible;
  logic [NUM_LEVELS-1:0][NUM_CH-1:0] levelMask;
  logic [NUM_CH-1:0] selMask, winner;
  logic [IDX_W-1:0] winIdx;

  assign eligible = chanReq & chanEn;
  assign anyElig  = |eligible;

  for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_level
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      assign levelMask[lv][c] = eligible[c] &&
        (chanPrio[PRIO_W*c +: PRIO_W] == PRIO_W'(lv));
    end
  end

  // stage one: highest populated level overrides lower ones
  always_comb begin
    selMask = '0;
    for (int lv = 0; lv < NUM_LEVELS; lv++)
      if (|levelMask[lv]) selMask = levelMask[lv];
  end

  // stage two: lowest set bit wins
  assign winner = selMask & (~selMask + NUM_CH'(1));

  always_comb begin
    winIdx = '0;
    for (int c = NUM_CH - 1; c >= 0; c--)
      if (winner[c]) winIdx = IDX_W'(c);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantOneHot <= '0;
      grantIdx    <= '0;
      grantValid  <= 1'b0;
    end else if (strb.loadGrant) begin
      grantOneHot <= winner;
      grantIdx    <= winIdx;
      grantValid  <= 1'b1;
    end else if (strb.clearGrant) begin
      grantOneHot <= '0;
      grantIdx    <= '0;
      grantValid  <= 1'b0;
    end
  end

  // R8: at most one grant bit, at the reported index
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOneHot) && (!grantValid || grantOneHot[grantIdx]));

  // R5: nothing shown when no grant is held
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> (grantIdx == '0 && grantOneHot == '0));

  // R6: held grant does not move before the beat completes
  a_r6_stable: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !beatDone) |=> ($stable(grantOneHot) && $stable(grantIdx) && grantValid));

  // R4: a fresh grant went to a channel that was eligible one cycle earlier
  a_r4_eligible: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) |-> ($past(eligible) & grantOneHot) != '0);
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        chanReq,
  input  logic [NUM_CH-1:0]        chanEn,
  input  logic [PRIO_W*NUM_CH-1:0] chanPrio,
  input  logic                     beatDone,
  output logic [NUM_CH-1:0]        grantOneHot,
  output logic [IDX_W-1:0]         grantIdx,
  output logic                     grantValid
);
  arbStrobe_t strb;
  logic anyElig;

  dma_arb_control i_control (
    .clk(clk), .rstN(rstN), .anyElig(anyElig), .beatDone(beatDone), .strb(strb)
  );

  dma_arb_datapath #(.NUM_CH(NUM_CH)) i_datapath (
    .clk(clk), .rstN(rstN), .chanReq(chanReq), .chanEn(chanEn),
    .chanPrio(chanPrio), .beatDone(beatDone), .strb(strb), .anyElig(anyElig),
    .grantOneHot(grantOneHot), .grantIdx(grantIdx), .grantValid(grantValid)
  );
endmodule

// File: tb/test_dma_prio_arbiter.sv
module test_dma_prio_arbiter;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] chanReq = '0, chanEn = '0;
  logic [2*N-1:0] chanPrio = '0;
  logic beatDone = 1'b0;
  logic [N-1:0] grantOneHot;
  logic [2:0] grantIdx;
  logic grantValid;

  int applied = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_prio_arbiter #(.NUM_CH(N)) i_dma_prio_arbiter (
    .clk(clk), .rstN(rstN), .chanReq(chanReq), .chanEn(chanEn), .chanPrio(chanPrio),
    .beatDone(beatDone), .grantOneHot(grantOneHot), .grantIdx(grantIdx),
    .grantValid(grantValid)
  );

  // {req, en, prio, valid, idx}
  typedef struct packed {
    logic [7:0] req; logic [7:0] en; logic [15:0] prio; logic vld; logic [2:0] idx;
  } vec_t;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 8'hFF, 16'h0000, 1'b1, 3'd0},  // R3 single
    '{8'h81, 8'hFF, 16'hC000, 1'b1, 3'd7},  // R2 high level beats low index
    '{8'h0C, 8'hFF, 16'h0050, 1'b1, 3'd2},  // R3 tie
    '{8'hF0, 8'hFF, 16'h7E00, 1'b1, 3'd5},  // R2 + R3
    '{8'h03, 8'hFE, 16'h0000, 1'b1, 3'd1},  // R4 ch0 disabled
    '{8'hFF, 8'h00, 16'hFFFF, 1'b0, 3'd0},  // R4 all disabled
    '{8'h00, 8'hFF, 16'hFFFF, 1'b0, 3'd0},  // R5 no request
    '{8'hFF, 8'hFF, 16'hFFFF, 1'b1, 3'd0},  // R3 all top
    '{8'h90, 8'hFF, 16'h8100, 1'b1, 3'd7},  // R2 level 2 over 1
    '{8'h06, 8'hFF, 16'h0030, 1'b1, 3'd2}   // R2 level 3 over 0
  };

  task automatic check(string req, logic v, logic [2:0] i);
    logic [N-1:0] oh;
    oh = v ? (N'(1) << i) : '0;
    applied++;
    if (grantValid !== v || grantIdx !== i || grantOneHot !== oh) begin
      bad++;
      $display("FAIL %s: got valid=%b idx=%0d oh=%b, expected valid=%b idx=%0d oh=%b",
               req, grantValid, grantIdx, grantOneHot, v, i, oh);
    end
  endtask

  task automatic finishBeat();
    @(negedge clk) beatDone = 1'b1;
    @(negedge clk) beatDone = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 3'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 3'd0);

    for (int k = 0; k < NV; k++) begin
      chanReq = VECS[k].req; chanEn = VECS[k].en; chanPrio = VECS[k].prio;
      @(negedge clk);
      check("R2/R3/R4/R5", VECS[k].vld, VECS[k].idx);
      if (VECS[k].vld) begin
        chanReq = '0;
        finishBeat();
        check("R7", 1'b0, 3'd0);
      end
    end

    // R6: grant ch3, then a stronger request arrives mid-beat
    chanEn = 8'hFF; chanPrio = 16'h0000; chanReq = 8'h08;
    @(negedge clk);
    check("R6", 1'b1, 3'd3);
    chanReq = 8'h09; chanPrio = 16'h0003;
    repeat (4) begin
      @(negedge clk);
      check("R6", 1'b1, 3'd3);
    end
    // R7: done -> idle cycle -> new grant to ch0
    finishBeat();
    check("R7", 1'b0, 3'd0);
    @(negedge clk);
    check("R7", 1'b1, 3'd0);
    chanReq = '0;
    finishBeat();

    // R9: beatDone while idle is ignored and does not block a pending grant
    beatDone = 1'b1;
    @(negedge clk);
    check("R9", 1'b0, 3'd0);
    chanReq = 8'h40;
    @(negedge clk);
    beatDone = 1'b0;
    check("R9", 1'b1, 3'd6);
    chanReq = '0;
    finishBeat();

    // R1: reset mid-grant clears outputs
    chanReq = 8'h20;
    @(negedge clk);
    check("R8", 1'b1, 3'd5);
    rstN = 1'b0;
    #1;
    check("R1", 1'b0, 3'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule